// File: doc/BRIEF.md
# One-Hot Serial Word Link

This block carries 32-bit words across a chip over five wires: four data rails and one acknowledge rail running back from receiver to sender. Each word leaves the sending end as sixteen 2-bit symbols. A symbol is a single raised rail whose index equals the symbol value. Every symbol is followed by an all-low spacer, so the receiver learns that a symbol is present from the rails alone and needs no strobe.

The sending end accepts a word through a valid/ready pair. It then walks a four-phase exchange per symbol:
1. It raises one rail.
2. It waits for the acknowledge to rise.
3. It drops all rails.
4. It waits for the acknowledge to fall.

The receiving end acknowledges each legal code and shifts the symbol into a word register. After the final spacer it offers the word on its own valid/ready pair. If two or more rails are high at once, it reports an error and does not acknowledge.

Both ends sit in one module with separate pins, so they can be wired back to back or each joined to a partner elsewhere. Both use one clock and sample the rails as levels.

Top module: `onehot_serial_link`

## Requirements
- R1: After reset: `wireOut` is 0, `ackOut` is 0, `outValid` is 0, `protoErr` is 0 and `inReady` is 1.
- R2: The sender encodes a symbol of value v (0..3) by raising only `wireOut[v]`. The first symbol of a word is bits [1:0], the next is bits [3:2], and so on.
- R3: The sender keeps a symbol steady until `ackIn` is high. It then drives all rails low and keeps them low until `ackIn` is low again, before it raises the next symbol.
- R4: `inReady` is high only while the sender is idle. It falls in the cycle after a word is accepted and returns only after the 16th spacer has been acknowledged.
- R5: When exactly one rail of `wireIn` is high, the receiver raises `ackOut` one cycle later. It holds `ackOut` high until `wireIn` is all low, and lowers it the cycle after that.
- R6: The receiver rebuilds the word with the first received symbol in bits [1:0] and the 16th in bits [31:30].
- R7: `outValid` rises only after the 16th symbol's spacer has been seen. With the two ends wired back to back, it rises 63 cycles after the edge that accepts the word.
- R8: While `outValid` is high and `outReady` is low, `outValid` and `outWord` stay unchanged and no new symbol is acknowledged. In that state a waiting sender stalls with its symbol raised.
- R9: A sample with two or more rails of `wireIn` high sets `protoErr` for the following cycle. That sample is not acknowledged and is not stored as a symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ends |
| rstN | input | 1 | Active-low synchronous reset |
| inWord | input | 32 | Word to send |
| inValid | input | 1 | `inWord` is offered |
| inReady | output | 1 | Sender idle, will take a word |
| wireOut | output | 4 | One-hot data rails leaving the sender |
| ackIn | input | 1 | Acknowledge returned to the sender |
| wireIn | input | 4 | One-hot data rails arriving at the receiver |
| ackOut | output | 1 | Acknowledge driven by the receiver |
| outWord | output | 32 | Rebuilt word |
| outValid | output | 1 | `outWord` is complete |
| outReady | input | 1 | Consumer takes the word |
| protoErr | output | 1 | Illegal multi-rail code seen in the previous cycle |

## Verification
Each side advances one step per clock edge:
- The sender raises the rails, and the receiver raises `ackOut`, on the edge after the condition they wait for.
- `protoErr` follows the offending sample by one cycle.
- A back-to-back word costs four edges per symbol, so `outValid` is due 63 edges after acceptance.

The bench changes inputs and reads outputs on falling edges, and counts rising edges from the acceptance edge. It compares the count to 63 exactly. In the hand-driven tests it reads each rail or acknowledge change one falling edge after the stimulus that causes it.

// File: rtl/osl_pkg.sv
package osl_pkg;
  typedef struct packed {
    logic load;
    logic shift;
  } txStrobeT;

  typedef struct packed {
    logic capture;
    logic advance;
    logic clear;
  } rxStrobeT;
endpackage

// File: rtl/osl_tx_path.sv
module osl_tx_path import osl_pkg::*; #(
  parameter int WORD_W = 32,
  parameter int SYM_W  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  txStrobeT                 strb,
  input  logic                     drive,
  input  logic [WORD_W-1:0]        inWord,
  output logic [(1 << SYM_W)-1:0]  wireOut,
  output logic                     lastSym
);
  localparam int WIRES = 1 << SYM_W;
  localparam int NSYM  = WORD_W / SYM_W;
  localparam int CNT_W = (NSYM > 1) ? $clog2(NSYM) : 1;

  logic [WORD_W-1:0] shiftReg;
  logic [CNT_W-1:0]  symCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      symCnt   <= '0;
    end else if (strb.load) begin
      shiftReg <= inWord;
      symCnt   <= '0;
    end else if (strb.shift) begin
      shiftReg <= shiftReg >> SYM_W;
      symCnt   <= symCnt + 1'b1;
    end
  end

  assign lastSym = (symCnt == CNT_W'(NSYM - 1));

  for (genvar g = 0; g < WIRES; g++) begin : g_rail
    assign wireOut[g] = drive && (shiftReg[SYM_W-1:0] == SYM_W'(g));
  end
endmodule

// File: rtl/osl_tx_ctrl.sv
module osl_tx_ctrl import osl_pkg::*; (
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     ackIn,
  input  logic     lastSym,
  output logic     inReady,
  output logic     drive,
  output txStrobeT strb
);
  typedef enum logic [1:0] {TX_IDLE, TX_DRIVE, TX_RELEASE} txStateT;
  txStateT state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= TX_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      TX_IDLE: if (inValid) begin
        strb.load = 1'b1;
        nextState = TX_DRIVE;
      end
      TX_DRIVE: if (ackIn) nextState = TX_RELEASE;
      TX_RELEASE: if (!ackIn) begin
        if (lastSym) nextState = TX_IDLE;
        else begin
          strb.shift = 1'b1;
          nextState  = TX_DRIVE;
        end
      end
      default: nextState = TX_IDLE;
    endcase
  end

  assign inReady = (state == TX_IDLE);
  assign drive   = (state == TX_DRIVE);
endmodule

// File: rtl/osl_rx_path.sv
module osl_rx_path import osl_pkg::*; #(
  parameter int WORD_W = 32,
  parameter int SYM_W  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rxStrobeT                 strb,
  input  logic [(1 << SYM_W)-1:0]  wireIn,
  output logic [WORD_W-1:0]        outWord,
  output logic                     symOk,
  output logic                     spacer,
  output logic                     lastSym,
  output logic                     protoErr
);
  localparam int WIRES = 1 << SYM_W;
  localparam int NSYM  = WORD_W / SYM_W;
  localparam int CNT_W = (NSYM > 1) ? $clog2(NSYM) : 1;

  logic [WORD_W-1:0] shiftReg;
  logic [CNT_W-1:0]  symCnt;
  logic [SYM_W-1:0]  symVal;
  logic              symBad;

  always_comb begin
    symVal = '0;
    for (int i = 0; i < WIRES; i++) begin
      if (wireIn[i]) symVal = symVal | SYM_W'(i);
    end
  end

  assign symOk  = ($countones(wireIn) == 1);
  assign symBad = ($countones(wireIn) > 1);
  assign spacer = (wireIn == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      symCnt   <= '0;
      protoErr <= 1'b0;
    end else begin
      protoErr <= symBad;
      if (strb.capture) shiftReg <= {symVal, shiftReg[WORD_W-1:SYM_W]};
      if (strb.clear)        symCnt <= '0;
      else if (strb.advance) symCnt <= symCnt + 1'b1;
    end
  end

  assign lastSym = (symCnt == CNT_W'(NSYM - 1));
  assign outWord = shiftReg;
endmodule

// File: rtl/osl_rx_ctrl.sv
module osl_rx_ctrl import osl_pkg::*; (
  input  logic     clk,
  input  logic     rstN,
  input  logic     symOk,
  input  logic     spacer,
  input  logic     lastSym,
  input  logic     outReady,
  output logic     ackOut,
  output logic     outValid,
  output rxStrobeT strb
);
  typedef enum logic [1:0] {RX_WAIT, RX_ACK, RX_FULL} rxStateT;
  rxStateT state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= RX_WAIT;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      RX_WAIT: if (symOk) begin
        strb.capture = 1'b1;
        nextState    = RX_ACK;
      end
      RX_ACK: if (spacer) begin
        if (lastSym) begin
          strb.clear = 1'b1;
          nextState  = RX_FULL;
        end else begin
          strb.advance = 1'b1;
          nextState    = RX_WAIT;
        end
      end
      RX_FULL: if (outReady) nextState = RX_WAIT;
      default: nextState = RX_WAIT;
    endcase
  end

  assign ackOut   = (state == RX_ACK);
  assign outValid = (state == RX_FULL);
endmodule

// File: rtl/onehot_serial_link.sv
module onehot_serial_link import osl_pkg::*; #(
  parameter int WORD_W = 32,
  parameter int SYM_W  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [WORD_W-1:0]        inWord,
  input  logic                     inValid,
  output logic                     inReady,
  output logic [(1 << SYM_W)-1:0]  wireOut,
  input  logic                     ackIn,
  input  logic [(1 << SYM_W)-1:0]  wireIn,
  output logic                     ackOut,
  output logic [WORD_W-1:0]        outWord,
  output logic                     outValid,
  input  logic                     outReady,
  output logic                     protoErr
);
  txStrobeT txStrb;
  rxStrobeT rxStrb;
  logic txDrive, txLast, rxOk, rxSpacer, rxLast;

  osl_tx_ctrl i_txCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ackIn(ackIn),
    .lastSym(txLast), .inReady(inReady), .drive(txDrive), .strb(txStrb)
  );

  osl_tx_path #(.WORD_W(WORD_W), .SYM_W(SYM_W)) i_txPath (
    .clk(clk), .rstN(rstN), .strb(txStrb), .drive(txDrive),
    .inWord(inWord), .wireOut(wireOut), .lastSym(txLast)
  );

  osl_rx_ctrl i_rxCtrl (
    .clk(clk), .rstN(rstN), .symOk(rxOk), .spacer(rxSpacer),
    .lastSym(rxLast), .outReady(outReady), .ackOut(ackOut),
    .outValid(outValid), .strb(rxStrb)
  );

  osl_rx_path #(.WORD_W(WORD_W), .SYM_W(SYM_W)) i_rxPath (
    .clk(clk), .rstN(rstN), .strb(rxStrb), .wireIn(wireIn),
    .outWord(outWord), .symOk(rxOk), .spacer(rxSpacer),
    .lastSym(rxLast), .protoErr(protoErr)
  );
endmodule

// File: rtl/osl_checker.sv
module osl_checker #(
  parameter int WORD_W = 32,
  parameter int SYM_W  = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic                     inReady,
  input logic [(1 << SYM_W)-1:0]  wireOut,
  input logic                     ackIn,
  input logic [(1 << SYM_W)-1:0]  wireIn,
  input logic                     ackOut,
  input logic [WORD_W-1:0]        outWord,
  input logic                     outValid,
  input logic                     outReady,
  input logic                     protoErr
);
  AST_TX_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wireOut)); // R2
  AST_TX_HOLD_SYM: assert property (@(posedge clk) disable iff (!rstN)
    (wireOut != '0 && !ackIn) |=> $stable(wireOut)); // R3
  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (wireOut != '0 && ackIn) |=> (wireOut == '0)); // R3
  AST_TX_WAIT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (wireOut == '0 && ackIn && !inReady) |=> (wireOut == '0)); // R3
  AST_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady); // R4
  AST_RX_ACK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ackOut && wireIn != '0) |=> ackOut); // R5
  AST_RX_HOLD_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outWord))); // R8
  AST_RX_BAD_NOACK: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(wireIn) > 1 && !ackOut) |=> !ackOut); // R9
  AST_RX_BAD_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(wireIn) > 1) |=> protoErr); // R9
endmodule

bind onehot_serial_link osl_checker #(.WORD_W(WORD_W), .SYM_W(SYM_W)) i_oslChecker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .wireOut(wireOut), .ackIn(ackIn), .wireIn(wireIn), .ackOut(ackOut),
  .outWord(outWord), .outValid(outValid), .outReady(outReady),
  .protoErr(protoErr)
);

// File: tb/test_onehot_serial_link.sv
`timescale 1ns/1ps
module test_onehot_serial_link;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] inWord = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [3:0]  wireOut;
  logic        ackIn;
  logic [3:0]  wireIn;
  logic        ackOut;
  logic [31:0] outWord;
  logic        outValid;
  logic        outReady = 1'b0;
  logic        protoErr;

  logic        loopBack = 1'b1;
  logic [3:0]  drvWires = '0;
  logic        drvAck = 1'b0;

  int checkCnt = 0;
  int failCnt  = 0;
  int cycles   = 0;

  assign wireIn = loopBack ? wireOut : drvWires;
  assign ackIn  = loopBack ? ackOut  : drvAck;

  always #2.5 clk = ~clk;

  onehot_serial_link i_onehot_serial_link (
    .clk(clk), .rstN(rstN), .inWord(inWord), .inValid(inValid),
    .inReady(inReady), .wireOut(wireOut), .ackIn(ackIn), .wireIn(wireIn),
    .ackOut(ackOut), .outWord(outWord), .outValid(outValid),
    .outReady(outReady), .protoErr(protoErr)
  );

  localparam int NVEC = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_A5A5,
    32'h1234_5678, 32'h8000_0001, 32'hDEAD_BEEF
  };

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [31:0] w);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inWord  = w;
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitOutValid(output int n);
    n = 0;
    while (!outValid && n < 1000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic rxSym(input logic [1:0] v);
    drvWires = 4'b0001 << v;
    @(negedge clk);
    drvWires = '0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [31:0] rxWord;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(wireOut == 4'b0, "R1 wireOut", 32'(wireOut), 32'h0);
    check(!ackOut && !outValid && !protoErr, "R1 ack/valid/err",
          {29'b0, ackOut, outValid, protoErr}, 32'h0);
    check(inReady, "R1 inReady", 32'(inReady), 32'h1);

    // R6 R7 loopback vectors, latency 63
    outReady = 1'b1;
    for (int k = 0; k < NVEC; k++) begin
      sendWord(VEC[k]);
      waitOutValid(lat);
      check(outWord == VEC[k], "R6 word", outWord, VEC[k]);
      check(lat == 63, "R7 latency", 32'(lat), 32'd63);
    end

    // R2 R3 R4 sender driven by hand
    repeat (3) @(negedge clk);
    loopBack = 1'b0;
    drvAck   = 1'b0;
    sendWord(32'h0000_0002);
    check(wireOut == 4'b0100, "R2 first symbol bits[1:0]", 32'(wireOut), 32'h4);
    check(!inReady, "R4 busy", 32'(inReady), 32'h0);
    repeat (3) @(negedge clk);
    check(wireOut == 4'b0100, "R3 hold without ack", 32'(wireOut), 32'h4);
    drvAck = 1'b1;
    @(negedge clk);
    check(wireOut == 4'b0000, "R3 release on ack", 32'(wireOut), 32'h0);
    repeat (2) @(negedge clk);
    check(wireOut == 4'b0000, "R3 low while ack high", 32'(wireOut), 32'h0);
    drvAck = 1'b0;
    @(negedge clk);
    check(wireOut == 4'b0001, "R2 second symbol", 32'(wireOut), 32'h1);
    for (int s = 1; s < 16; s++) begin
      while (wireOut == 4'b0) @(negedge clk);
      drvAck = 1'b1;
      while (wireOut != 4'b0) @(negedge clk);
      drvAck = 1'b0;
      @(negedge clk);
    end
    @(negedge clk);
    check(inReady, "R4 ready after last spacer", 32'(inReady), 32'h1);

    // R5 R6 R7 R9 receiver driven by hand
    outReady = 1'b0;
    drvWires = 4'b0011;
    @(negedge clk);
    check(protoErr, "R9 error flag", 32'(protoErr), 32'h1);
    check(!ackOut, "R9 no ack on bad code", 32'(ackOut), 32'h0);
    drvWires = 4'b0000;
    @(negedge clk);
    check(!protoErr, "R9 flag clears", 32'(protoErr), 32'h0);
    rxWord = 32'hC3A5_0F96;
    drvWires = 4'b0001 << rxWord[1:0];
    @(negedge clk);
    check(ackOut, "R5 ack rises", 32'(ackOut), 32'h1);
    repeat (2) @(negedge clk);
    check(ackOut, "R5 ack held", 32'(ackOut), 32'h1);
    drvWires = 4'b0000;
    @(negedge clk);
    check(!ackOut, "R5 ack falls", 32'(ackOut), 32'h0);
    for (int s = 1; s < 15; s++) rxSym(rxWord[2*s +: 2]);
    drvWires = 4'b0001 << rxWord[31:30];
    @(negedge clk);
    check(!outValid, "R7 not valid before last spacer", 32'(outValid), 32'h0);
    drvWires = 4'b0000;
    @(negedge clk);
    check(outValid, "R7 valid after last spacer", 32'(outValid), 32'h1);
    check(outWord == rxWord, "R6 order", outWord, rxWord);

    // R8 hold while not taken
    drvWires = 4'b0001;
    repeat (3) @(negedge clk);
    check(!ackOut, "R8 no ack while full", 32'(ackOut), 32'h0);
    check(outValid && outWord == rxWord, "R8 word held", outWord, rxWord);
    drvWires = 4'b0000;
    outReady = 1'b1;
    @(negedge clk);
    check(!outValid, "R8 released on ready", 32'(outValid), 32'h0);

    // R8 loopback backpressure stalls the sender
    repeat (2) @(negedge clk);
    loopBack = 1'b1;
    outReady = 1'b0;
    sendWord(32'h1111_2222);
    waitOutValid(lat);
    sendWord(32'h3333_4444);
    repeat (10) @(negedge clk);
    check(!inReady && wireOut != 4'b0 && !ackOut, "R8 sender stalled",
          {27'b0, inReady, wireOut, ackOut}, 32'h0);
    check(outValid && outWord == 32'h1111_2222, "R8 first word held",
          outWord, 32'h1111_2222);
    outReady = 1'b1;
    @(negedge clk);
    waitOutValid(lat);
    check(outWord == 32'h3333_4444, "R6 second word after stall",
          outWord, 32'h3333_4444);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule